// File: doc/BRIEF.md
# SDRAM Device Command Decoder

This block is the synchronous control core of a small two-bank, 32-bit low-power SDRAM, modelled from the memory's side of the bus. On every rising clock edge it samples the command strobes, bank select, address, clock enable and the four byte masks. It decodes the command, keeps an open/closed flag and an open row for each bank, and steps a column counter through a burst. Write data goes into a small inferred array. Read data comes out after the programmed CAS latency, with byte enables.

A controller first loads the mode register. It then opens a row with ACTIVE and issues READ or WRITE bursts. Rows are closed with PRECHARGE, or with auto precharge on the READ or WRITE itself. The bidirectional data bus is split into `dq_in`, `dq_out` and a per-byte output enable `dq_oe`. A cleared `dq_oe` bit stands for a high-Z byte.

Top module: `lpsdram_ctrl`

## Requirements
- R1: When `cs_n` is high at an edge, the command lines are ignored: no data is written, no read burst starts and `cmd_err` stays low.
- R2: Command code {ras_n,cas_n,we_n}: 011 activate, 101 read, 100 write, 010 precharge, 110 burst stop, 000 mode load, 001 and 111 no-op. Activate latches `addr` as the row of bank `bs`. Read and write use `addr[7:0]` as the column. Data written to one bank and column reads back unchanged, and is kept separate from the same column of the other bank.
- R3: During a write beat, each byte whose `dqm` bit (bit b covers bits 8b+7..8b) is high at that edge keeps its stored value. The other bytes take `dq_in`.
- R4: Mode load stores `addr[6:0]`: bits 2:0 are the burst-length code, bit 3 selects interleaved order, and bits 6:4 are the CAS latency (3 gives latency 3, any other value gives 2). With latency L, beat i of a read issued at edge k is driven after edge k+i+L-1 and up to the following edge. Reset sets the latency to 2, sequential order and length 1.
- R5: A high `dqm` bit sampled at edge m clears that byte of `dq_oe`, and forces that byte of `dq_out` to zero, in the cycle after edge m+1.
- R6: Length codes 0,1,2,3 give bursts of 1,2,4,8 beats. Sequential order counts up from the start column and wraps inside the block of that size.
- R7: Interleaved order (mode bit 3 set, length 2 to 8) visits the start column XOR the beat number, inside the block of that size.
- R8: Length code 7 (codes 4 to 6 act the same) gives a full-page burst. It counts up through 256 columns, wraps within the row, and stops only on burst stop, precharge or a new read or write. No beat follows the stop.
- R9: A read or write with `addr[10]` high closes its bank at the edge of its last beat.
- R10: Precharge with `addr[10]` high closes both banks. With `addr[10]` low it closes only bank `bs`. A precharge ends any running burst.
- R11: A read or write to a bank with no open row raises `cmd_err` for one cycle after that edge, and is otherwise ignored.
- R12: An edge with `cke` low ignores all commands and moves no state. If no burst is running, `pwr_down` goes high after that edge. It goes low after the first edge with `cke` high.
- R13: While `cke` is low during a burst, the burst and the read pipeline hold (clock suspend). `pwr_down` stays low, and the remaining beats continue once `cke` returns high.
- R14: After synchronous reset, both banks are closed, no burst runs, and `dq_oe`, `cmd_err` and `pwr_down` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; low freezes the device |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command bit |
| cas_n | input | 1 | Column strobe command bit |
| we_n | input | 1 | Write enable command bit |
| bs | input | 1 | Bank select |
| addr | input | 11 | Row, column, auto-precharge flag or mode value |
| dqm | input | 4 | Per-byte mask |
| dq_in | input | 32 | Write data |
| dq_out | output | 32 | Read data, zero in bytes not driven |
| dq_oe | output | 4 | Per-byte output enable (low means high-Z) |
| cmd_err | output | 1 | Access to a closed bank was rejected |
| pwr_down | output | 1 | Device is in power-down |

## Verification
A vector table writes a full word, then overwrites it through different byte-mask patterns in both banks, and reads each word back. A wrong lane mapping, a write mask that acts late, or banks that alias each other all show up in the merged word. Directed bursts start from columns in the middle of their blocks, in both sequential and interleaved order and across the full-page row end. A wrong order or wrap point therefore shows as a mismatched beat. Clock suspend, read masking and CAS latency 3 are timed beat by beat, so an extra or missing delay register gives a shifted word.

// File: rtl/lps_pkg.sv
package lps_pkg;

    localparam int DATA_W = 32;
    localparam int NBYTE  = DATA_W / 8;
    localparam int ADDR_W = 11;
    localparam int ROW_W  = ADDR_W;
    localparam int COL_W  = 8;
    localparam int NBANK  = 2;
    localparam int BANK_W = $clog2(NBANK);
    localparam int AP_BIT = 10;

    typedef enum logic [2:0] {
        C_NOP, C_LMR, C_ACT, C_RD, C_WR, C_PRE, C_BST, C_REF
    } cmd_e;

    typedef struct packed {
        logic [2:0] cl;
        logic       ilv;
        logic [2:0] blc;
    } mode_t;

    localparam mode_t MODE_RST = 7'h20;

    function automatic logic [COL_W-1:0] blk_mask(input logic [2:0] blc);
        case (blc)
            3'd0:    return 8'h00;
            3'd1:    return 8'h01;
            3'd2:    return 8'h03;
            3'd3:    return 8'h07;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [8:0] burst_len(input logic [2:0] blc);
        return {1'b0, blk_mask(blc)} + 9'd1;
    endfunction

    function automatic logic [COL_W-1:0] burst_col(input logic [COL_W-1:0] start,
                                                   input logic [COL_W-1:0] idx,
                                                   input logic [2:0]       blc,
                                                   input logic             ilv);
        logic [COL_W-1:0] m;
        logic [COL_W-1:0] off;
        m = blk_mask(blc);
        if (ilv && blc < 3'd4) off = (start ^ idx) & m;
        else                   off = (start + idx) & m;
        return (start & ~m) | off;
    endfunction

endpackage

// File: rtl/lps_cmd_decode.sv
module lps_cmd_decode
    import lps_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        if (cs_n) begin
            cmd = C_NOP;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b000:  cmd = C_LMR;
                3'b001:  cmd = C_REF;
                3'b010:  cmd = C_PRE;
                3'b011:  cmd = C_ACT;
                3'b100:  cmd = C_WR;
                3'b101:  cmd = C_RD;
                3'b110:  cmd = C_BST;
                default: cmd = C_NOP;
            endcase
        end
    end

endmodule

// File: rtl/lps_bank_table.sv
module lps_bank_table
    import lps_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        en,
    input  cmd_e                        cmd,
    input  logic [BANK_W-1:0]           bsel,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        ap_close,
    input  logic [BANK_W-1:0]           ap_bank,
    output logic [NBANK-1:0]            open_o,
    output logic [NBANK-1:0][ROW_W-1:0] row_o
);

    logic [NBANK-1:0]            open_q;
    logic [NBANK-1:0][ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= '0;
            row_q  <= '0;
        end else begin
            if (ap_close) open_q[ap_bank] <= 1'b0;
            if (en) begin
                case (cmd)
                    C_ACT: begin
                        open_q[bsel] <= 1'b1;
                        row_q[bsel]  <= addr;
                    end
                    C_PRE: begin
                        if (addr[AP_BIT]) open_q <= '0;
                        else              open_q[bsel] <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign open_o = open_q;
    assign row_o  = row_q;

    AST_PRE_ALL_SHUT: assert property (@(posedge clk) disable iff (rst)
        (en && cmd == C_PRE && addr[AP_BIT]) |=> (open_o == '0)); // R10

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
        (en && cmd == C_ACT) |=> open_o[$past(bsel)]); // R2

endmodule

// File: rtl/lps_burst_seq.sv
module lps_burst_seq
    import lps_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               start,
    input  logic               stop,
    input  logic               start_wr,
    input  logic               start_ap,
    input  logic [BANK_W-1:0]  bank_in,
    input  logic [COL_W-1:0]   col_in,
    input  mode_t              mode,
    output logic               beat_v,
    output logic               beat_wr,
    output logic [BANK_W-1:0]  beat_bank,
    output logic [COL_W-1:0]   beat_col,
    output logic               ap_close,
    output logic [BANK_W-1:0]  ap_bank,
    output logic               busy
);

    logic              busy_q, wr_q, ap_q, ilv_q;
    logic [BANK_W-1:0] bank_q;
    logic [COL_W-1:0]  start_q, idx_q;
    logic [2:0]        blc_q;
    logic              last, ap_sel;
    logic [8:0]        len_q;

    assign len_q = burst_len(blc_q);

    always_comb begin
        beat_v    = 1'b0;
        beat_wr   = wr_q;
        beat_bank = bank_q;
        beat_col  = burst_col(start_q, idx_q, blc_q, ilv_q);
        last      = 1'b0;
        ap_sel    = ap_q;
        if (start) begin
            beat_v    = 1'b1;
            beat_wr   = start_wr;
            beat_bank = bank_in;
            beat_col  = col_in;
            last      = (mode.blc == 3'd0);
            ap_sel    = start_ap;
        end else if (busy_q && !stop) begin
            beat_v = 1'b1;
            last   = (len_q != 9'd256) && ({1'b0, idx_q} == len_q - 9'd1);
        end
    end

    assign ap_close = en && beat_v && last && ap_sel;
    assign ap_bank  = beat_bank;
    assign busy     = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            wr_q    <= 1'b0;
            ap_q    <= 1'b0;
            ilv_q   <= 1'b0;
            bank_q  <= '0;
            start_q <= '0;
            idx_q   <= '0;
            blc_q   <= '0;
        end else if (en) begin
            if (start) begin
                busy_q  <= (mode.blc != 3'd0);
                wr_q    <= start_wr;
                ap_q    <= start_ap;
                ilv_q   <= mode.ilv;
                bank_q  <= bank_in;
                start_q <= col_in;
                idx_q   <= 8'd1;
                blc_q   <= mode.blc;
            end else if (stop) begin
                busy_q <= 1'b0;
            end else if (busy_q) begin
                idx_q <= idx_q + 8'd1;
                if (last) busy_q <= 1'b0;
            end
        end
    end

    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (rst)
        (en && stop && !start) |=> !busy); // R8

    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(idx_q) && $stable(busy))); // R13

    AST_BL1_IDLE: assert property (@(posedge clk) disable iff (rst)
        (en && start && mode.blc == 3'd0) |=> !busy); // R6

endmodule

// File: rtl/lpsdram_ctrl.sv
module lpsdram_ctrl
    import lps_pkg::*;
#(
    parameter int ROW_KEEP = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] bs,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NBYTE-1:0]  dqm,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic [NBYTE-1:0]  dq_oe,
    output logic              cmd_err,
    output logic              pwr_down
);

    localparam int IDX_W = BANK_W + ROW_KEEP + COL_W;
    localparam int DEPTH = 1 << IDX_W;

    cmd_e                        cmd;
    mode_t                       mode_q;
    logic [NBANK-1:0]            bank_open;
    logic [NBANK-1:0][ROW_W-1:0] bank_row;
    logic                        rw_req, tgt_open, start, stop;
    logic                        beat_v, beat_wr, ap_close, busy, fire;
    logic [BANK_W-1:0]           beat_bank, ap_bank;
    logic [COL_W-1:0]            beat_col;
    logic [IDX_W-1:0]            idx;
    logic [ROW_W-1:0]            beat_row;
    logic                        row_hi_unused;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [2:0]        pv;
    logic [DATA_W-1:0] pd0, pd1, pd2, tap_d;
    logic              tap_v;
    logic [NBYTE-1:0]  dm1, dm2;

    lps_cmd_decode u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
    );

    assign rw_req   = cke && (cmd == C_RD || cmd == C_WR);
    assign tgt_open = bank_open[bs];
    assign start    = (cmd == C_RD || cmd == C_WR) && tgt_open;
    assign stop     = (cmd == C_BST || cmd == C_PRE);

    lps_bank_table u_banks (
        .clk(clk), .rst(rst), .en(cke), .cmd(cmd), .bsel(bs), .addr(addr),
        .ap_close(ap_close), .ap_bank(ap_bank),
        .open_o(bank_open), .row_o(bank_row)
    );

    lps_burst_seq u_burst (
        .clk(clk), .rst(rst), .en(cke), .start(start), .stop(stop),
        .start_wr(cmd == C_WR), .start_ap(addr[AP_BIT]),
        .bank_in(bs), .col_in(addr[COL_W-1:0]), .mode(mode_q),
        .beat_v(beat_v), .beat_wr(beat_wr), .beat_bank(beat_bank),
        .beat_col(beat_col), .ap_close(ap_close), .ap_bank(ap_bank),
        .busy(busy)
    );

    assign beat_row      = bank_row[beat_bank];
    assign row_hi_unused = ^beat_row[ROW_W-1:ROW_KEEP];
    assign idx           = {beat_bank, beat_row[ROW_KEEP-1:0], beat_col};
    assign fire          = cke && beat_v;

    always_ff @(posedge clk) begin
        if (rst)                       mode_q <= MODE_RST;
        else if (cke && cmd == C_LMR)  mode_q <= mode_t'(addr[6:0]);
    end

    always_ff @(posedge clk) begin
        if (fire && beat_wr) begin
            for (int b = 0; b < NBYTE; b++) begin
                if (!dqm[b]) mem[idx][b*8 +: 8] <= dq_in[b*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pv  <= '0;
            dm1 <= '0;
            dm2 <= '0;
        end else if (cke) begin
            pv  <= {pv[1:0], fire && !beat_wr};
            dm1 <= dqm;
            dm2 <= dm1;
        end
    end

    always_ff @(posedge clk) begin
        if (cke) begin
            pd0 <= mem[idx];
            pd1 <= pd0;
            pd2 <= pd1;
        end
    end

    assign tap_v = (mode_q.cl == 3'd3) ? pv[2] : pv[1];
    assign tap_d = (mode_q.cl == 3'd3) ? pd2 : pd1;

    for (genvar g = 0; g < NBYTE; g++) begin : g_lane
        assign dq_oe[g]          = tap_v && !dm2[g];
        assign dq_out[g*8 +: 8]  = dq_oe[g] ? tap_d[g*8 +: 8] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_err  <= 1'b0;
            pwr_down <= 1'b0;
        end else begin
            cmd_err  <= rw_req && !tgt_open;
            pwr_down <= !cke && !busy;
        end
    end

    AST_PD_IDLE: assert property (@(posedge clk) disable iff (rst)
        pwr_down |-> !busy); // R12

    AST_AP_SHUT: assert property (@(posedge clk) disable iff (rst)
        (ap_close && !(cke && cmd == C_ACT && bs == ap_bank))
        |=> !bank_open[$past(ap_bank)]); // R9

    AST_ERR_NO_START: assert property (@(posedge clk) disable iff (rst)
        (rw_req && !tgt_open && !busy) |=> !busy); // R11

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cs_n && !busy) |=> (!busy && !cmd_err)); // R1

endmodule

// File: tb/sim_lpsdram_ctrl.sv
module sim_lpsdram_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke = 1'b1;
    logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [0:0]  bs = 1'b0;
    logic [10:0] addr = '0;
    logic [3:0]  dqm = '0;
    logic [31:0] dq_in = '0;
    logic [31:0] dq_out;
    logic [3:0]  dq_oe;
    logic        cmd_err, pwr_down;

    int nchk = 0;
    int nerr = 0;

    localparam logic [3:0] K_NOP  = 4'b0111;
    localparam logic [3:0] K_LMR  = 4'b0000;
    localparam logic [3:0] K_ACT  = 4'b0011;
    localparam logic [3:0] K_RD   = 4'b0101;
    localparam logic [3:0] K_WR   = 4'b0100;
    localparam logic [3:0] K_PRE  = 4'b0010;
    localparam logic [3:0] K_BST  = 4'b0110;
    localparam logic [3:0] K_DESR = 4'b1101;
    localparam logic [3:0] K_DESW = 4'b1100;

    // {bank, col, first word, second word, second-write mask}
    localparam logic [76:0] VEC [6] = '{
        {1'b0, 8'h10, 32'h11223344, 32'hAABBCCDD, 4'b0000},
        {1'b1, 8'h10, 32'h55667788, 32'h99AABBCC, 4'b1111},
        {1'b0, 8'h20, 32'h01020304, 32'hF0E0D0C0, 4'b0101},
        {1'b1, 8'hFF, 32'hDEADBEEF, 32'h12345678, 4'b1000},
        {1'b0, 8'h00, 32'hCAFEF00D, 32'h0BADC0DE, 4'b0011},
        {1'b1, 8'h7F, 32'h76543210, 32'hFEDCBA98, 4'b0110}
    };

    lpsdram_ctrl u0 (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .bs(bs), .addr(addr), .dqm(dqm),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .cmd_err(cmd_err), .pwr_down(pwr_down)
    );

    always #10 clk = ~clk;

    task automatic drive(input logic [3:0] c, input logic b, input logic [10:0] a,
                         input logic [3:0] m, input logic [31:0] d);
        {cs_n, ras_n, cas_n, we_n} = c;
        bs = b; addr = a; dqm = m; dq_in = d;
        @(posedge clk);
        #1;
    endtask

    task automatic nop();
        drive(K_NOP, 1'b0, 11'h0, 4'h0, 32'h0);
    endtask

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_word(input string req, input logic [31:0] exp);
        chk(dq_out === exp && dq_oe === 4'hF, req, dq_out, exp);
    endtask

    task automatic chk_idle(input string req);
        chk(dq_oe === 4'h0, req, {28'h0, dq_oe}, 32'h0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        #(20 * 100000);
        nerr++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [76:0] v;
        logic [31:0] exp;
        logic [31:0] d [4];
        for (int i = 0; i < 4; i++) d[i] = 32'hA0000000 + 32'(i * 17 + 1);

        nop(); nop();
        rst = 1'b0;
        nop();
        // R14 reset state
        chk(dq_oe === 4'h0 && cmd_err === 1'b0 && pwr_down === 1'b0, "R14",
            {dq_oe, 26'h0, cmd_err, pwr_down}, 32'h0);

        // R11 read to closed bank
        drive(K_RD, 1'b0, 11'h000, 4'h0, 32'h0);
        chk(cmd_err === 1'b1, "R11 err", {31'h0, cmd_err}, 32'h1);
        nop();
        chk(cmd_err === 1'b0, "R11 err one cycle", {31'h0, cmd_err}, 32'h0);
        chk_idle("R11 no data");

        drive(K_LMR, 1'b0, 11'h020, 4'h0, 32'h0);
        drive(K_ACT, 1'b0, 11'h000, 4'h0, 32'h0);
        drive(K_ACT, 1'b1, 11'h001, 4'h0, 32'h0);

        // R2 / R3 table: full write, masked overwrite, read back
        for (int i = 0; i < 6; i++) begin
            v = VEC[i];
            drive(K_WR, v[76], {3'b0, v[75:68]}, 4'h0, v[67:36]);
            drive(K_WR, v[76], {3'b0, v[75:68]}, v[3:0], v[35:4]);
            drive(K_RD, v[76], {3'b0, v[75:68]}, 4'h0, 32'h0);
            nop();
            for (int b = 0; b < 4; b++)
                exp[b*8 +: 8] = v[b] ? v[36 + b*8 +: 8] : v[4 + b*8 +: 8];
            chk_word("R2 R3 masked write readback", exp);
        end
        drive(K_RD, 1'b0, 11'h010, 4'h0, 32'h0);
        nop();
        chk_word("R2 bank separation", 32'hAABBCCDD);

        // R1 deselected commands do nothing
        drive(K_DESW, 1'b0, 11'h010, 4'h0, 32'h0);
        drive(K_DESR, 1'b0, 11'h010, 4'h0, 32'h0);
        chk(cmd_err === 1'b0, "R1 no err", {31'h0, cmd_err}, 32'h0);
        nop();
        chk_idle("R1 no read");
        drive(K_RD, 1'b0, 11'h010, 4'h0, 32'h0);
        nop();
        chk_word("R1 write ignored", 32'hAABBCCDD);

        // R6 BL4 sequential, write 0x40..0x43, read from 0x42
        drive(K_LMR, 1'b0, 11'h022, 4'h0, 32'h0);
        drive(K_WR, 1'b0, 11'h040, 4'h0, d[0]);
        drive(K_NOP, 1'b0, 11'h0, 4'h0, d[1]);
        drive(K_NOP, 1'b0, 11'h0, 4'h0, d[2]);
        drive(K_NOP, 1'b0, 11'h0, 4'h0, d[3]);
        drive(K_RD, 1'b0, 11'h042, 4'h0, 32'h0);
        nop(); chk_word("R6 beat0 col42", d[2]);
        nop(); chk_word("R6 beat1 col43", d[3]);
        nop(); chk_word("R6 beat2 wrap col40", d[0]);
        nop(); chk_word("R6 beat3 col41", d[1]);
        nop(); chk_idle("R6 burst ends");

        // R7 interleaved BL4 from 0x41: 41,40,43,42
        drive(K_LMR, 1'b0, 11'h02A, 4'h0, 32'h0);
        drive(K_RD, 1'b0, 11'h041, 4'h0, 32'h0);
        nop(); chk_word("R7 beat0", d[1]);
        nop(); chk_word("R7 beat1", d[0]);
        nop(); chk_word("R7 beat2", d[3]);
        nop(); chk_word("R7 beat3", d[2]);

        // R4 CAS latency 3
        drive(K_LMR, 1'b0, 11'h032, 4'h0, 32'h0);
        drive(K_RD, 1'b0, 11'h040, 4'h0, 32'h0);
        nop(); chk_idle("R4 CL3 not yet");
        nop(); chk_word("R4 CL3 beat0", d[0]);
        nop(); chk_word("R4 CL3 beat1", d[1]);
        nop(); nop(); nop();

        // R5 read mask two-clock latency
        drive(K_LMR, 1'b0, 11'h022, 4'h0, 32'h0);
        drive(K_RD, 1'b0, 11'h040, 4'h0, 32'h0);
        drive(K_NOP, 1'b0, 11'h0, 4'h1, 32'h0);
        chk_word("R5 beat0 unmasked", d[0]);
        nop();
        chk(dq_oe === 4'hE && dq_out === (d[1] & 32'hFFFFFF00), "R5 beat1 byte0 off",
            dq_out, d[1] & 32'hFFFFFF00);
        nop(); chk_word("R5 beat2 unmasked", d[2]);
        nop(); nop();

        // R8 full page wrap and stop
        drive(K_LMR, 1'b0, 11'h027, 4'h0, 32'h0);
        drive(K_WR, 1'b0, 11'h0FE, 4'h0, 32'hE0E0E0E0);
        drive(K_NOP, 1'b0, 11'h0, 4'h0, 32'hE1E1E1E1);
        drive(K_NOP, 1'b0, 11'h0, 4'h0, 32'hE2E2E2E2);
        drive(K_NOP, 1'b0, 11'h0, 4'h0, 32'hE3E3E3E3);
        drive(K_BST, 1'b0, 11'h0, 4'h0, 32'hFFFFFFFF);
        drive(K_LMR, 1'b0, 11'h020, 4'h0, 32'h0);
        drive(K_RD, 1'b0, 11'h000, 4'h0, 32'h0);
        nop(); chk_word("R8 col0 written by wrap", 32'hE2E2E2E2);
        drive(K_LMR, 1'b0, 11'h027, 4'h0, 32'h0);
        drive(K_RD, 1'b0, 11'h0FE, 4'h0, 32'h0);
        nop(); chk_word("R8 beat0", 32'hE0E0E0E0);
        nop(); chk_word("R8 beat1", 32'hE1E1E1E1);
        nop(); chk_word("R8 beat2 wrapped", 32'hE2E2E2E2);
        drive(K_BST, 1'b0, 11'h0, 4'h0, 32'h0);
        chk_word("R8 beat3", 32'hE3E3E3E3);
        nop(); chk_idle("R8 stopped");

        // R9 auto precharge with BL2
        drive(K_LMR, 1'b0, 11'h021, 4'h0, 32'h0);
        drive(K_RD, 1'b0, 11'h440, 4'h0, 32'h0);
        nop(); chk_word("R9 beat0", d[0]);
        drive(K_RD, 1'b0, 11'h040, 4'h0, 32'h0);
        chk(cmd_err === 1'b1, "R9 bank closed", {31'h0, cmd_err}, 32'h1);
        chk_word("R9 beat1", d[1]);
        nop(); chk_idle("R9 read after close ignored");
        drive(K_ACT, 1'b0, 11'h000, 4'h0, 32'h0);

        // R10 single and all precharge
        drive(K_PRE, 1'b1, 11'h000, 4'h0, 32'h0);
        drive(K_RD, 1'b0, 11'h040, 4'h0, 32'h0);
        chk(cmd_err === 1'b0, "R10 other bank open", {31'h0, cmd_err}, 32'h0);
        drive(K_RD, 1'b1, 11'h010, 4'h0, 32'h0);
        chk(cmd_err === 1'b1, "R10 selected bank closed", {31'h0, cmd_err}, 32'h1);
        drive(K_ACT, 1'b1, 11'h001, 4'h0, 32'h0);
        drive(K_PRE, 1'b0, 11'h400, 4'h0, 32'h0);
        drive(K_RD, 1'b0, 11'h040, 4'h0, 32'h0);
        chk(cmd_err === 1'b1, "R10 all closed b0", {31'h0, cmd_err}, 32'h1);
        drive(K_RD, 1'b1, 11'h010, 4'h0, 32'h0);
        chk(cmd_err === 1'b1, "R10 all closed b1", {31'h0, cmd_err}, 32'h1);
        drive(K_ACT, 1'b0, 11'h000, 4'h0, 32'h0);
        drive(K_ACT, 1'b1, 11'h001, 4'h0, 32'h0);

        // R11 write to closed bank ignored
        drive(K_LMR, 1'b0, 11'h020, 4'h0, 32'h0);
        drive(K_PRE, 1'b1, 11'h000, 4'h0, 32'h0);
        drive(K_WR, 1'b1, 11'h010, 4'h0, 32'h0);
        chk(cmd_err === 1'b1, "R11 write err", {31'h0, cmd_err}, 32'h1);
        drive(K_ACT, 1'b1, 11'h001, 4'h0, 32'h0);
        drive(K_RD, 1'b1, 11'h010, 4'h0, 32'h0);
        nop(); chk_word("R11 data kept", 32'h55667788);

        // R12 power-down, commands ignored
        cke = 1'b0;
        drive(K_PRE, 1'b0, 11'h400, 4'h0, 32'h0);
        chk(pwr_down === 1'b1, "R12 enter", {31'h0, pwr_down}, 32'h1);
        nop();
        cke = 1'b1;
        nop();
        chk(pwr_down === 1'b0, "R12 exit", {31'h0, pwr_down}, 32'h0);
        drive(K_RD, 1'b0, 11'h040, 4'h0, 32'h0);
        chk(cmd_err === 1'b0, "R12 precharge ignored", {31'h0, cmd_err}, 32'h0);
        nop(); chk_word("R12 read after exit", d[0]);

        // R13 clock suspend in a BL4 read
        drive(K_LMR, 1'b0, 11'h022, 4'h0, 32'h0);
        drive(K_RD, 1'b0, 11'h040, 4'h0, 32'h0);
        cke = 1'b0;
        nop();
        chk(pwr_down === 1'b0 && dq_oe === 4'h0, "R13 suspend no pd",
            {27'h0, dq_oe, pwr_down}, 32'h0);
        nop(); chk_idle("R13 held");
        cke = 1'b1;
        nop(); chk_word("R13 beat0", d[0]);
        nop(); chk_word("R13 beat1", d[1]);
        nop(); chk_word("R13 beat2", d[2]);
        nop(); chk_word("R13 beat3", d[3]);
        nop(); chk_idle("R13 done");

        summary();
        $finish;
    end

endmodule